// File: doc/BRIEF.md
# Root Contention Back-off Arbiter

This block runs on one port of a bus node when that node and the peer on the far end of the same link both ask to be parent during tree building. Both sides then ask to be the root. The block settles the tie. It stops requesting and drives idle, then tosses a biased coin to pick a short or a long back-off. It counts time ticks until its back-off runs out, and then reads what the peer is doing. If the peer is still requesting, this node acknowledges and becomes root. If the peer has gone quiet (idle), this node requests again. An acknowledge from the peer then makes this node the child. A request from the peer means both sides retried together, and a new round starts with a new coin.

The line carries one of four symbols, coded on two bits: 0 idle, 1 request, 2 acknowledge, 3 quiet (nothing driven). A free-running 16-bit LFSR makes the coin. Its low byte is compared with an 8-bit threshold. A per-node offset input places the exact expiry point inside the chosen window. A round counter records how many times the node has fallen back into contention. The root and child results hold until a synchronous restart.

Top module: `root_contend_ctrl`

## Requirements
- R1: After reset, or one cycle after `restart` is sampled high, `tx_line` is 3 (quiet), `is_root` and `is_child` are 0 and `round_cnt` is 0. `restart` has priority over `start`.
- R2: A `start` sampled in the quiet state gives one cycle of `tx_line` = 1 (contention, still requesting). During the whole back-off that follows, `tx_line` = 0 (idle).
- R3: The coin is read in the contention cycle. `fast_thr` = 0 always gives the slow window. `fast_thr` = 255 always gives the fast window. Any other value gives the fast window with probability `fast_thr`/256.
- R4: The back-off counter starts at 0 on entering the wait. The wait ends at the count min(lo + `exp_offset`, hi), where lo/hi are 76/85 for fast and 159/167 for slow. The node acts on the next clock edge. With `tick` held high, the result is visible after edge start+target+2.
- R5: If the peer's last request/idle symbol at expiry was request (1), the node drives acknowledge (2) and raises `is_root`.
- R6: If the peer's last request/idle symbol at expiry was idle (0), the node drives request (1) and waits for an answer.
- R7: While waiting for an answer, a received acknowledge (2) raises `is_child` and sets `tx_line` to quiet (3).
- R8: While waiting for an answer, a received request (1) returns the node to contention. `round_cnt` increases by one, and a new coin and back-off follow.
- R9: During the back-off, received idle selects the idle variant and received request selects the request variant. Switching variants never resets the back-off counter.
- R10: An idle from the peer seen in the contention cycle puts the node straight into the idle variant of the chosen window.
- R11: `is_root` and `is_child` are never both high. Each stays high, with `start` ignored, until `restart`.
- R12: The back-off counter advances only on clock edges where `tick` is high.
- R13: Received acknowledge (2) or quiet (3) during the back-off changes neither the variant nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the quiet state, clears results and round count |
| start | input | 1 | Enter contention (taken only in the quiet state) |
| tick | input | 1 | Time-base pulse that advances the back-off counter |
| rx_line | input | 2 | Symbol received from the peer (0 idle, 1 request, 2 acknowledge, 3 quiet) |
| fast_thr | input | 8 | Coin threshold for the fast window |
| exp_offset | input | 8 | Expiry offset above the window minimum, sampled in the contention cycle |
| tx_line | output | 2 | Symbol driven to the peer, same coding as rx_line |
| is_root | output | 1 | Node won and is root (sticky) |
| is_child | output | 1 | Node lost and is child (sticky) |
| round_cnt | output | 8 | Number of returns to contention since restart |

## Verification
The hardest cases to reach from the ports are a simultaneous retry and a variant change that lands on the last tick before expiry. Both depend on a random coin and on a back-off of more than a hundred ticks. The stimulus takes the coin out of the way by driving the threshold to 0 or 255. The expiry point is then known exactly, and the bench keeps its own count of ticks and of the last request/idle symbol it drove. At that point it can answer the repeated request with a request, or let random line symbols and random tick gaps reach the final edge. One run at threshold 128 checks that both windows really occur.

// File: rtl/rc_pkg.sv
package rc_pkg;

   typedef enum logic [1:0] {
      LN_IDLE  = 2'd0,
      LN_REQ   = 2'd1,
      LN_ACK   = 2'd2,
      LN_QUIET = 2'd3
   } line_sym_t;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_CONTEND,
      ST_WAIT,
      ST_REQSENT,
      ST_ROOT,
      ST_CHILD
   } arb_state_t;

endpackage

// File: rtl/rc_coin.sv
module rc_coin #(
   parameter int          LFSR_W = 16,
   parameter int          THR_W  = 8,
   parameter logic [15:0] SEED   = 16'hB5C3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [THR_W-1:0] thr,
   output logic             fast
);

   logic [LFSR_W-1:0] lfsr_q;
   logic              fb;

   if (THR_W > LFSR_W) begin : g_bad_thr
      $error("rc_coin: threshold wider than LFSR");
   end

   generate
      if (LFSR_W == 16) begin : g_l16
         assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
      end else if (LFSR_W == 8) begin : g_l8
         assign fb = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
      end else begin : g_lbad
         $error("rc_coin: unsupported LFSR width");
         assign fb = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr_q <= LFSR_W'(SEED) | LFSR_W'(1);
      end else begin
         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      end
   end

   // all-ones threshold forces the fast outcome
   assign fast = (&thr) || (lfsr_q[THR_W-1:0] < thr);

endmodule

// File: rtl/rc_backoff_timer.sv
module rc_backoff_timer #(
   parameter int CNT_W = 8,
   parameter int OFF_W = 8,
   parameter int F_MIN = 76,
   parameter int F_MAX = 85,
   parameter int S_MIN = 159,
   parameter int S_MAX = 167
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             fast_sel,
   input  logic [OFF_W-1:0] offset,
   input  logic             run,
   input  logic             tick,
   output logic             expired,
   output logic [CNT_W-1:0] cnt
);

   localparam int OFF_MAX   = (1 << OFF_W) - 1;
   localparam bit NEED_CLMP = (F_MIN + OFF_MAX > F_MAX) || (S_MIN + OFF_MAX > S_MAX);

   if (OFF_W > CNT_W) begin : g_bad_off
      $error("rc_backoff_timer: offset wider than counter");
   end

   logic [CNT_W-1:0] win_lo, win_hi, tgt_d, tgt_q, cnt_q;
   logic [CNT_W:0]   sum;

   assign win_lo = fast_sel ? CNT_W'(F_MIN) : CNT_W'(S_MIN);
   assign win_hi = fast_sel ? CNT_W'(F_MAX) : CNT_W'(S_MAX);
   assign sum    = {1'b0, win_lo} + (CNT_W+1)'(offset);

   generate
      if (NEED_CLMP) begin : g_clamp
         assign tgt_d = (sum > {1'b0, win_hi}) ? win_hi : sum[CNT_W-1:0];
      end else begin : g_noclamp
         assign tgt_d = sum[CNT_W] ? win_hi : sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= CNT_W'(S_MAX);
      end else if (clr) begin
         cnt_q <= '0;
         tgt_q <= tgt_d;
      end else if (run && tick && (cnt_q < CNT_W'(S_MAX))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = run && (cnt_q >= tgt_q);
   assign cnt     = cnt_q;

endmodule

// File: rtl/rc_arb_fsm.sv
module rc_arb_fsm #(
   parameter int RND_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             start,
   input  logic [1:0]       rx,
   input  logic             expired,
   output logic             tmr_clr,
   output logic             tmr_run,
   output logic [1:0]       tx,
   output logic             root,
   output logic             child,
   output logic [RND_W-1:0] rounds
);
   import rc_pkg::*;

   arb_state_t       st_q, st_d;
   logic             pidle_q, pidle_d;
   logic [RND_W-1:0] rnd_q, rnd_d;

   always_comb begin
      st_d    = st_q;
      pidle_d = pidle_q;
      rnd_d   = rnd_q;
      if (restart) begin
         st_d    = ST_OFF;
         pidle_d = 1'b0;
         rnd_d   = '0;
      end else begin
         unique case (st_q)
            ST_OFF: begin
               if (start) st_d = ST_CONTEND;
            end
            ST_CONTEND: begin
               st_d    = ST_WAIT;
               pidle_d = (rx == LN_IDLE);
            end
            ST_WAIT: begin
               if (expired) begin
                  st_d = pidle_q ? ST_REQSENT : ST_ROOT;
               end else if (rx == LN_IDLE) begin
                  pidle_d = 1'b1;
               end else if (rx == LN_REQ) begin
                  pidle_d = 1'b0;
               end
            end
            ST_REQSENT: begin
               if (rx == LN_ACK) begin
                  st_d = ST_CHILD;
               end else if (rx == LN_REQ) begin
                  st_d  = ST_CONTEND;
                  rnd_d = rnd_q + 1'b1;
               end
            end
            ST_ROOT, ST_CHILD: st_d = st_q;
            default: st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_OFF;
         pidle_q <= 1'b0;
         rnd_q   <= '0;
      end else begin
         st_q    <= st_d;
         pidle_q <= pidle_d;
         rnd_q   <= rnd_d;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_CONTEND, ST_REQSENT: tx = LN_REQ;
         ST_WAIT:                tx = LN_IDLE;
         ST_ROOT:                tx = LN_ACK;
         default:                tx = LN_QUIET;
      endcase
   end

   assign tmr_clr = (st_q == ST_CONTEND);
   assign tmr_run = (st_q == ST_WAIT);
   assign root    = (st_q == ST_ROOT);
   assign child   = (st_q == ST_CHILD);
   assign rounds  = rnd_q;

endmodule

// File: rtl/root_contend_ctrl.sv
module root_contend_ctrl #(
   parameter int F_MIN = 76,
   parameter int F_MAX = 85,
   parameter int S_MIN = 159,
   parameter int S_MAX = 167,
   parameter int OFF_W = 8,
   parameter int THR_W = 8,
   parameter int RND_W = 8,
   parameter int LFSR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             start,
   input  logic             tick,
   input  logic [1:0]       rx_line,
   input  logic [THR_W-1:0] fast_thr,
   input  logic [OFF_W-1:0] exp_offset,
   output logic [1:0]       tx_line,
   output logic             is_root,
   output logic             is_child,
   output logic [RND_W-1:0] round_cnt
);

   localparam int CNT_W = $clog2(S_MAX + 1);

   if (F_MIN > F_MAX || S_MIN > S_MAX || F_MAX >= S_MIN || F_MIN < 1) begin : g_bad_win
      $error("root_contend_ctrl: back-off windows out of order");
   end

   logic             coin_fast, tmr_clr, tmr_run, tmr_exp;
   logic [CNT_W-1:0] tmr_cnt;

   rc_coin #(.LFSR_W(LFSR_W), .THR_W(THR_W)) u_coin (
      .clk  (clk),
      .rst_n(rst_n),
      .thr  (fast_thr),
      .fast (coin_fast)
   );

   rc_backoff_timer #(
      .CNT_W(CNT_W), .OFF_W(OFF_W),
      .F_MIN(F_MIN), .F_MAX(F_MAX), .S_MIN(S_MIN), .S_MAX(S_MAX)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .fast_sel(coin_fast),
      .offset  (exp_offset),
      .run     (tmr_run),
      .tick    (tick),
      .expired (tmr_exp),
      .cnt     (tmr_cnt)
   );

   rc_arb_fsm #(.RND_W(RND_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(restart),
      .start  (start),
      .rx     (rx_line),
      .expired(tmr_exp),
      .tmr_clr(tmr_clr),
      .tmr_run(tmr_run),
      .tx     (tx_line),
      .root   (is_root),
      .child  (is_child),
      .rounds (round_cnt)
   );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
   parameter int F_MIN = 76,
   parameter int S_MAX = 167,
   parameter int CNT_W = 8,
   parameter int RND_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             restart,
   input logic [1:0]       tx_line,
   input logic             is_root,
   input logic             is_child,
   input logic [RND_W-1:0] round_cnt,
   input logic             tmr_run,
   input logic [CNT_W-1:0] tmr_cnt
);

   assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!is_root && !is_child && round_cnt == '0 && tx_line == 2'd3));

   assert_wait_drives_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_run |-> tx_line == 2'd0);

   assert_no_early_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_root) |-> $past(tmr_cnt) >= CNT_W'(F_MIN));

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_cnt <= CNT_W'(S_MAX));

   assert_root_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_root |-> tx_line == 2'd2);

   assert_round_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (round_cnt == $past(round_cnt)) ||
                   (round_cnt == RND_W'($past(round_cnt) + 1'b1)));

   assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_root && is_child));

   assert_root_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_root && !restart) |=> is_root);

   assert_child_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_child && !restart) |=> is_child);

endmodule

bind root_contend_ctrl rc_checker #(
   .F_MIN(F_MIN), .S_MAX(S_MAX), .CNT_W(CNT_W), .RND_W(RND_W)
) i_rc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .tx_line  (tx_line),
   .is_root  (is_root),
   .is_child (is_child),
   .round_cnt(round_cnt),
   .tmr_run  (tmr_run),
   .tmr_cnt  (tmr_cnt)
);

// File: tb/test_root_contend_ctrl.sv
module test_root_contend_ctrl;

   localparam logic [1:0] L_IDLE = 2'd0, L_REQ = 2'd1, L_ACK = 2'd2, L_QUIET = 2'd3;

   logic       clk = 1'b0, rst_n = 1'b0, restart = 1'b0, start = 1'b0, tick = 1'b1;
   logic [1:0] rx_line = L_REQ;
   logic [7:0] fast_thr = 8'd0, exp_offset = 8'd0;
   logic [1:0] tx_line;
   logic       is_root, is_child;
   logic [7:0] round_cnt;

   int n_cmp = 0, n_bad = 0, cyc = 0;

   root_contend_ctrl i_root_contend_ctrl (
      .clk(clk), .rst_n(rst_n), .restart(restart), .start(start), .tick(tick),
      .rx_line(rx_line), .fast_thr(fast_thr), .exp_offset(exp_offset),
      .tx_line(tx_line), .is_root(is_root), .is_child(is_child), .round_cnt(round_cnt)
   );

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tgt(input bit fast, input int off);
      int lo = fast ? 76 : 159;
      int hi = fast ? 85 : 167;
      return (lo + off > hi) ? hi : lo + off;
   endfunction

   task automatic do_restart();
      @(negedge clk); restart = 1'b1;
      @(negedge clk); restart = 1'b0;
   endtask

   // leaves the bench at the negedge inside the contention cycle, rx_init driven
   task automatic begin_round(input logic [1:0] rx_init);
      @(negedge clk); start = 1'b1; rx_line = L_REQ;
      @(negedge clk); start = 1'b0;
      chk(tx_line == L_REQ, "R2 contention drives request", tx_line, L_REQ);
      rx_line = rx_init;
   endtask

   task automatic run_wait(input int target, input bit rnd_tick, input int rx_mode,
                           inout bit pidle, input string tag);
      int  n = 0, k = 0;
      bit  stayed = 1'b1;
      logic [1:0] r;
      logic t;
      @(posedge clk);
      forever begin
         @(negedge clk);
         if (tx_line != L_IDLE || is_root || is_child) stayed = 1'b0;
         t = rnd_tick ? logic'($urandom % 2) : 1'b1;
         case (rx_mode)
            0: r = rx_line;
            1: r = 2'($urandom % 4);
            default: r = (k >= 10 && k < 30) ? L_IDLE : L_REQ;
         endcase
         tick = t; rx_line = r;
         @(posedge clk);
         k++;
         if (n >= target) break;
         if (t) n++;
         if (r == L_IDLE) pidle = 1'b1;
         else if (r == L_REQ) pidle = 1'b0;
      end
      tick = 1'b1;
      chk(stayed, {tag, " no early result, idle driven"}, stayed, 1);
      @(negedge clk);
      if (!pidle)
         chk(is_root && tx_line == L_ACK, {tag, " R5 root with ack"}, {is_root, tx_line}, 6);
      else
         chk(!is_root && !is_child && tx_line == L_REQ, {tag, " R6 request sent"}, tx_line, L_REQ);
   endtask

   initial begin
      bit pidle;
      int k, nfast, rc;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_line == L_QUIET && !is_root && !is_child && round_cnt == 0,
          "R1 reset state", {tx_line, is_root, is_child}, 12);

      // slow forced, peer keeps requesting
      fast_thr = 8'd0; exp_offset = 8'd0;
      begin_round(L_REQ); pidle = 0;
      run_wait(tgt(0, 0), 0, 0, pidle, "R3 R4 slow");
      do_restart();
      chk(tx_line == L_QUIET && !is_root && round_cnt == 0, "R1 restart clears", tx_line, L_QUIET);

      // fast forced, then start ignored while root
      fast_thr = 8'hFF; exp_offset = 8'd3;
      begin_round(L_REQ); pidle = 0;
      run_wait(tgt(1, 3), 0, 0, pidle, "R3 R4 fast");
      @(negedge clk); start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      chk(is_root && !is_child && tx_line == L_ACK, "R11 root sticky, start ignored", is_root, 1);
      do_restart();

      // clamp to window maximum
      exp_offset = 8'd200;
      begin_round(L_REQ); pidle = 0;
      run_wait(85, 0, 0, pidle, "R4 clamp");
      do_restart();

      // idle seen in contention cycle, then acknowledge -> child
      exp_offset = 8'd0;
      begin_round(L_IDLE); pidle = 1;
      run_wait(tgt(1, 0), 0, 0, pidle, "R10 idle at contention");
      rx_line = L_ACK;
      @(negedge clk);
      chk(is_child && !is_root && tx_line == L_QUIET, "R7 child on ack", {is_child, tx_line}, 7);
      rx_line = L_REQ;
      repeat (3) @(negedge clk);
      chk(is_child, "R11 child sticky", is_child, 1);
      do_restart();

      // variant flips without timer reset
      begin_round(L_REQ); pidle = 0;
      run_wait(tgt(1, 0), 0, 2, pidle, "R9 variant flip");
      do_restart();

      // simultaneous retry, twice
      begin_round(L_IDLE); pidle = 1;
      run_wait(tgt(1, 0), 0, 0, pidle, "R8 pre-collision");
      for (int c = 1; c <= 2; c++) begin
         rx_line = L_REQ;
         @(negedge clk);
         chk(tx_line == L_REQ && round_cnt == 8'(c), "R8 back to contention",
             round_cnt, c);
         rx_line = (c == 1) ? L_IDLE : L_REQ;
         pidle = (c == 1);
         run_wait(tgt(1, 0), 0, 0, pidle, "R8 new round");
      end
      chk(is_root && round_cnt == 8'd2, "R8 round count kept", round_cnt, 2);
      do_restart();

      // random tick gaps and random line symbols
      fast_thr = 8'd0; exp_offset = 8'd5;
      begin_round(L_REQ); pidle = 0;
      run_wait(tgt(0, 5), 1, 1, pidle, "R12 R13 gated tick");
      do_restart();

      // unbiased coin gives both windows
      fast_thr = 8'd128; exp_offset = 8'd0; nfast = 0;
      for (int t = 0; t < 40; t++) begin
         begin_round(L_REQ);
         k = 0;
         while (!is_root && k < 400) begin @(negedge clk); k++; end
         if (k < 120) nfast++;
         do_restart();
         repeat ($urandom % 7) @(negedge clk);
      end
      chk(nfast >= 8 && nfast <= 32, "R3 half threshold mixes windows", nfast, 20);

      // constrained random trials
      for (int t = 0; t < 25; t++) begin
         bit f = bit'($urandom % 2);
         int off = $urandom % 128;
         logic [1:0] ri = ($urandom % 2) ? L_IDLE : L_REQ;
         fast_thr = f ? 8'hFF : 8'h00; exp_offset = 8'(off);
         begin_round(ri); pidle = (ri == L_IDLE);
         run_wait(tgt(f, off), bit'($urandom % 2), 1, pidle, "R4 R13 random");
         if (pidle) begin
            if ($urandom % 2) begin
               rx_line = L_ACK;
               @(negedge clk);
               chk(is_child && tx_line == L_QUIET, "R7 random child", is_child, 1);
            end else begin
               rc = round_cnt;
               rx_line = L_REQ;
               @(negedge clk);
               chk(round_cnt == 8'(rc + 1) && tx_line == L_REQ, "R8 random retry",
                   round_cnt, rc + 1);
            end
         end
         do_restart();
         chk(!is_root && !is_child && round_cnt == 0, "R1 random restart", round_cnt, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule